// File: doc/BRIEF.md
# Timing Oscillator with Offset Steering

This block is a numerically controlled oscillator that paces sample processing. A 32-bit phase accumulator advances every clock by a step equal to a programmed center frequency, plus an offset frequency when the offset is switched on. The accumulator's carry-out leaves the block as a one-cycle tick. The current phase leaves the block as an 8-bit value, which is the top of the accumulator rotated by a programmable phase offset.

Software writes control fields through a small register-write port. New center, offset and phase values are only staged by these writes. They become active when a frequency commit or a phase commit is written, so an update lands atomically. The offset word comes in bit by bit on a separate serial input, and its width is selectable. The accumulator can be held at zero by a clear control. It can be restarted from zero on every commit, or on a synchronized rising edge of an external sync input.

Top module: `timing_nco`

## Requirements
- R1: After reset, every register is zero: tick is low and phase reads 0.
- R2: With the offset disabled, the accumulator adds the active center word every clock. Tick is high in the cycle after an addition that overflows 32 bits, and low otherwise.
- R3: A write to address 1 stages a center word, and has no effect until a write to address 3 (frequency commit). On the edge that samples that commit, the staged center and the newly formed offset become active.
- R4: Each cycle with ser_valid high shifts ser_bit into a 32-bit shift register, MSB first. On a frequency commit, the active offset becomes the last N bits shifted in, placed in the top N bits of the word with zeros below. N is 8, 16, 24 or 32 for control bits [4:3] = 0, 1, 2 or 3.
- R5: Control bit 2 set adds the active offset to the center to form the step (modulo 2^32). Clear, the offset is ignored.
- R6: A write to address 2 stages an 8-bit phase offset. It becomes active on a write to address 4 (phase commit). The phase output always equals accumulator bits [31:24] plus the active phase offset, modulo 256.
- R7: While control bit 1 (clear) is set, the accumulator is zero and tick is low on the next edge. This overrides every other update.
- R8: With control bit 0 set, a frequency or phase commit restarts the accumulator at zero and holds tick low on that edge.
- R9: With control bit 5 set, a rising edge of sync_in restarts the accumulator at zero on the third clock edge after it is sampled. The edge passes through a two-flop synchronizer and an edge detector. A held-high level restarts only once. With bit 5 clear, sync_in has no effect.
- R10: With control bit 0 clear, a commit does not interrupt stepping. The edge that samples the commit still adds the old step, and the next edge adds the new one.
- R11: A write to address 0 loads control bits [5:0]. Addresses 0 to 4 are the only ones decoded.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 3 | Register address (0 control, 1 center, 2 phase, 3 frequency commit, 4 phase commit) |
| wr_data | input | 32 | Write data |
| ser_valid | input | 1 | Serial offset bit valid |
| ser_bit | input | 1 | Serial offset bit, MSB first |
| sync_in | input | 1 | Asynchronous external sync |
| tick | output | 1 | Registered accumulator carry-out |
| phase | output | 8 | Accumulator top byte plus phase offset |

## Verification
Two restart causes can hit the same edge: a commit with load-on-update set, and a detected sync edge. The clear control can also overlap either of them. The bench raises sync_in so that its detected edge lines up with a commit. It also repeats the overlap while clear is held. The bench judges the result by tick and by the phase trajectory on later cycles, using a cycle model built from the requirements: a single restart to zero, with clear winning, and no second restart from the held sync level.

// File: rtl/timing_nco.sv
module timing_nco #(
  parameter int ACC_W = 32,
  parameter int PH_W  = 8,
  parameter int AW    = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [AW-1:0]    wr_addr,
  input  logic [ACC_W-1:0] wr_data,
  input  logic             ser_valid,
  input  logic             ser_bit,
  input  logic             sync_in,
  output logic             tick,
  output logic [PH_W-1:0]  phase
);
  localparam int SEG = ACC_W / 4;

  logic [5:0]       ctl_q;
  logic [ACC_W-1:0] cen_s, cen_q, off_q, sh_q, acc_q, off_new;
  logic [PH_W-1:0]  ph_s, ph_q;
  logic [2:0]       sy;
  logic             tick_q;

  wire fstb   = wr_en && (wr_addr == AW'(3));
  wire pstb   = wr_en && (wr_addr == AW'(4));
  wire rise   = sy[1] & ~sy[2];
  wire reload = (ctl_q[0] & (fstb | pstb)) | (ctl_q[5] & rise);
  wire [ACC_W-1:0] step = cen_q + (ctl_q[2] ? off_q : '0);
  wire [ACC_W:0]   sum  = {1'b0, acc_q} + {1'b0, step};

  always_comb begin
    case (ctl_q[4:3])
      2'd0:    off_new = {sh_q[SEG-1:0],   {3*SEG{1'b0}}};
      2'd1:    off_new = {sh_q[2*SEG-1:0], {2*SEG{1'b0}}};
      2'd2:    off_new = {sh_q[3*SEG-1:0], {SEG{1'b0}}};
      default: off_new = sh_q;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctl_q <= '0; cen_s <= '0; ph_s <= '0; sh_q <= '0;
      cen_q <= '0; off_q <= '0; ph_q <= '0; sy <= '0;
    end else begin
      sy <= {sy[1:0], sync_in};
      if (ser_valid) sh_q <= {sh_q[ACC_W-2:0], ser_bit};
      if (fstb) begin
        cen_q <= cen_s;
        off_q <= off_new;
      end
      if (pstb) ph_q <= ph_s;
      if (wr_en) begin
        case (wr_addr)
          AW'(0):  ctl_q <= wr_data[5:0];
          AW'(1):  cen_s <= wr_data;
          AW'(2):  ph_s  <= wr_data[PH_W-1:0];
          default: ;
        endcase
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      acc_q <= '0; tick_q <= 1'b0;
    end else if (ctl_q[1] || reload) begin
      acc_q <= '0; tick_q <= 1'b0;
    end else begin
      acc_q <= sum[ACC_W-1:0]; tick_q <= sum[ACC_W];
    end
  end

  assign tick  = tick_q;
  assign phase = acc_q[ACC_W-1 -: PH_W] + ph_q;
endmodule

// File: rtl/timing_nco_chk.sv
module timing_nco_chk #(
  parameter int ACC_W = 32,
  parameter int AW    = 3
) (
  input logic             clk,
  input logic             rst_n,
  input logic             wr_en,
  input logic [AW-1:0]    wr_addr,
  input logic [5:0]       ctl_q,
  input logic [ACC_W-1:0] acc_q,
  input logic [ACC_W-1:0] cen_q,
  input logic [2:0]       sy,
  input logic             tick
);
  logic commit, edge_seen, restart;
  assign commit    = wr_en && (wr_addr == AW'(3) || wr_addr == AW'(4));
  assign edge_seen = sy[1] && !sy[2];
  assign restart   = (ctl_q[0] && commit) || (ctl_q[5] && edge_seen);

  assert_clear_zero_R7: assert property (@(posedge clk) disable iff (!rst_n)
    ctl_q[1] |=> (acc_q == '0 && !tick));

  assert_commit_restart_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (ctl_q[0] && commit) |=> (acc_q == '0 && !tick));

  assert_sync_restart_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (ctl_q[5] && edge_seen) |=> acc_q == '0);

  assert_center_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !(wr_en && wr_addr == AW'(3)) |=> $stable(cen_q));

  assert_tick_wrap_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (!ctl_q[1] && !restart) |=> (tick == (acc_q < $past(acc_q))));
endmodule

bind timing_nco timing_nco_chk #(.ACC_W(ACC_W), .AW(AW)) u_chk (.*);

// File: tb/sim_timing_nco.sv
module sim_timing_nco;
  logic clk = 1'b0, rst_n = 1'b0;
  logic wr_en = 1'b0, ser_valid = 1'b0, ser_bit = 1'b0, sync_in = 1'b0;
  logic [2:0]  wr_addr = '0;
  logic [31:0] wr_data = '0;
  logic        tick;
  logic [7:0]  phase;

  always #2 clk = ~clk;

  timing_nco u0 (.clk, .rst_n, .wr_en, .wr_addr, .wr_data, .ser_valid,
                 .ser_bit, .sync_in, .tick, .phase);

  int checks = 0, fails = 0;
  bit done = 1'b0;
  string req = "R1";

  logic [5:0]  m_ctl = '0;
  logic [31:0] m_cen_s = '0, m_cen = '0, m_off = '0, m_sh = '0, m_acc = '0;
  logic [7:0]  m_ph_s = '0, m_ph = '0;
  logic [2:0]  m_sy = '0;
  logic        m_tick = 1'b0;

  task automatic check();
    logic [7:0] ep;
    ep = m_acc[31:24] + m_ph;
    checks++;
    if (tick !== m_tick || phase !== ep) begin
      fails++;
      $display("FAIL %s t=%0t tick=%b phase=%h expected tick=%b phase=%h",
               req, $time, tick, phase, m_tick, ep);
    end
  endtask

  task automatic cyc();
    logic [32:0] s;
    logic [31:0] st, no;
    logic fs, ps, rl;
    fs = wr_en && wr_addr == 3'd3;
    ps = wr_en && wr_addr == 3'd4;
    rl = (m_ctl[0] && (fs || ps)) || (m_ctl[5] && m_sy[1] && !m_sy[2]);
    st = m_cen + (m_ctl[2] ? m_off : 32'd0);
    s  = {1'b0, m_acc} + {1'b0, st};
    no = m_sh << (8 * (3 - int'(m_ctl[4:3])));
    @(posedge clk);
    if (m_ctl[1] || rl) begin m_acc = '0; m_tick = 1'b0; end
    else {m_tick, m_acc} = s;
    if (fs) begin m_cen = m_cen_s; m_off = no; end
    if (ps) m_ph = m_ph_s;
    if (wr_en) begin
      if (wr_addr == 3'd0) m_ctl = wr_data[5:0];
      if (wr_addr == 3'd1) m_cen_s = wr_data;
      if (wr_addr == 3'd2) m_ph_s = wr_data[7:0];
    end
    if (ser_valid) m_sh = {m_sh[30:0], ser_bit};
    m_sy = {m_sy[1:0], sync_in};
    @(negedge clk);
    check();
  endtask

  task automatic run(int n);
    for (int i = 0; i < n; i++) cyc();
  endtask

  task automatic wr(logic [2:0] a, logic [31:0] d);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    cyc();
    wr_en = 1'b0;
  endtask

  task automatic ser_load(int n, logic [31:0] v);
    for (int i = n - 1; i >= 0; i--) begin
      ser_valid = 1'b1; ser_bit = v[i];
      cyc();
    end
    ser_valid = 1'b0;
  endtask

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog expired");
      summary();
      $finish;
    end
  end

  initial begin
    logic [31:0] cens [4];
    logic [7:0]  phs  [3];
    cens[0] = 32'h4000_0000; cens[1] = 32'h8000_0001;
    cens[2] = 32'hFFFF_FFFF; cens[3] = 32'h0123_4567;
    phs[0] = 8'h30; phs[1] = 8'hF0; phs[2] = 8'h81;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    req = "R1"; check(); run(3);

    req = "R3"; wr(3'd1, 32'h4000_0000); run(3);
    req = "R10"; wr(3'd3, 0);
    req = "R2"; run(12);
    foreach (cens[k]) begin
      req = "R7"; wr(3'd0, 32'h2); run(2); wr(3'd0, 0);
      req = "R3"; wr(3'd1, cens[k]); run(2);
      req = "R2"; wr(3'd3, 0); run(20);
    end

    foreach (phs[k]) begin
      req = "R6"; wr(3'd2, {24'h0, phs[k]}); run(3); wr(3'd4, 0); run(5);
    end

    req = "R11"; wr(3'd5, 32'hFFFF_FFFF); wr(3'd7, 32'h3F); run(4);

    for (int c = 0; c < 4; c++) begin
      req = "R4"; wr(3'd1, 32'h0000_1000);
      ser_load(8 * (c + 1), 32'hA5C3_9617 ^ (32'h1111_1111 * c));
      wr(3'd0, (c << 3) | 32'h4);
      wr(3'd3, 0); run(10);
      req = "R5"; wr(3'd0, c << 3); run(6);
      wr(3'd0, (c << 3) | 32'h4); run(4);
    end
    req = "R5"; wr(3'd1, 32'hF000_0000); ser_load(8, 8'h20);
    wr(3'd0, 32'h4); wr(3'd3, 0); run(8);

    req = "R10"; wr(3'd0, 0); wr(3'd1, 32'h2345_6789); wr(3'd3, 0); run(6);
    req = "R8"; wr(3'd0, 32'h1); run(3); wr(3'd1, 32'h1000_0001); wr(3'd3, 0); run(4);
    wr(3'd2, 32'h55); wr(3'd4, 0); run(4);

    req = "R9"; wr(3'd0, 0); sync_in = 1'b1; run(6); sync_in = 1'b0; run(3);
    wr(3'd0, 32'h20); run(2);
    for (int d = 0; d < 4; d++) begin
      sync_in = 1'b1; run(1 + d); run(10); sync_in = 1'b0; run(4);
    end

    req = "R9"; wr(3'd0, 32'h21); run(3);
    for (int d = 0; d < 4; d++) begin
      sync_in = 1'b1; run(d); wr(3'd3, 0); run(6); sync_in = 1'b0; run(3);
    end
    req = "R7"; wr(3'd0, 32'h23);
    sync_in = 1'b1; cyc(); wr(3'd3, 0); run(4); sync_in = 1'b0;
    wr(3'd0, 32'h21); run(8);

    done = 1'b1;
    summary();
    $finish;
  end
endmodule